// File: doc/BRIEF.md
# Framed Synchronous Receiver

This block turns a serial bit stream into checked 8-bit characters. Each received bit arrives with a one-cycle strobe on the system clock. The block first searches for a frame start. It then assembles characters least significant bit first and runs a 16-bit cyclic check over the data. Every character goes into a 64-entry FIFO. Two status bits travel with each character: check match and block end. Both are valid only while their own character is at the FIFO head.

The block has two modes:

- **Byte mode:** the frame starts with a programmable synchronisation character.
- **Bit mode:** frames are delimited by flags, stuffed zeros are removed, and a run of ones aborts the frame.

The host reads the FIFO through a valid/ready stream:

- `out_vld` is high whenever the FIFO head holds a character.
- A character leaves the FIFO on each clock edge where `out_vld` and `out_rdy` are both high.
- `out_rdy` has no effect while `out_vld` is low.
- The FIFO cannot push back on the line. A character that completes while the FIFO is full, and no pop happens on the same edge, is discarded.

Top module: `rxf_receiver`

## Requirements
- R1: In byte mode (`mode`=0) the receiver searches for `sync_char` at every bit position. Once a sync character is found, it checks the following 8-bit characters. It becomes active on the first character that differs from `sync_char` and follows two or more consecutive sync characters, and that character is stored. A non-sync character that follows a single sync character sends the receiver back to searching, and nothing is stored. The first received bit of a character is its bit 0.
- R2: Once active in byte mode, every following group of 8 bits is stored as a character, including those equal to `sync_char`. `rx_active` stays high until `clr`.
- R3: The byte-mode check uses the polynomial x16+x15+x2+1. It starts at zero with the first stored character and shifts the bits in received order. `out_match` is 1 with a character exactly when the check register is zero after that character.
- R4: In bit mode (`mode`=1):
  - A 0 that follows five consecutive 1s is deleted.
  - The sequence 0, six 1s, 0 is a flag.
  - Seven consecutive 1s abort the frame. On an abort, the held character is dropped, `rx_active` falls, and the receiver waits for a new flag.
- R5: In bit mode, the receiver becomes active on the first character completed after a flag. The check uses x16+x12+x5+1, starts at 0xFFFF at each flag, and shifts the bits in received order. `out_match` is 1 when the register equals 0x1D0F after that character.
- R6: In bit mode, a character is stored only once the next character or the closing flag arrives. On a closing flag, the last character is stored with `out_blkend`=1 and `rx_active` falls. All other characters carry `out_blkend`=0.
- R7:
  - `out_vld` is high exactly when the FIFO holds a character.
  - Characters leave in arrival order.
  - While the head is not popped, `out_data`, `out_match` and `out_blkend` hold steady.
- R8: The FIFO keeps 64 characters. A character that completes while the FIFO is full and no pop happens is discarded, and the stored characters are unchanged.
- R9: A one-cycle `clr` empties the FIFO, restarts the check and returns the receiver to searching with `rx_active` low.
- R10: After reset, `out_vld` and `rx_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush and return to searching |
| mode | input | 1 | 0 byte mode, 1 bit mode |
| sync_char | input | 8 | Byte-mode synchronisation character |
| rx_bit_vld | input | 1 | Strobe: `rx_bit` carries a new line bit |
| rx_bit | input | 1 | Serial line data |
| out_vld | output | 1 | FIFO head holds a character |
| out_rdy | input | 1 | Host read strobe, pops the head when `out_vld` is high |
| out_data | output | 8 | Character at the FIFO head |
| out_match | output | 1 | Check matched after this character |
| out_blkend | output | 1 | This character closed a bit-mode frame |
| rx_active | output | 1 | Receiver is inside a frame |

## Verification
The hardest case to reach from the ports is a bit-mode closing flag that lands just after a check byte whose trailing ones, together with the flag's own ones, come close to an abort run. The same applies to characters whose ones force stuffed zeros right at a character boundary. The stimulus encodes frames in the bench with its own zero-stuffing encoder. It mixes random payloads with directed runs of 0xFF and 0x7E bytes, and it appends both correct and corrupted check bytes, so that the delayed store of the block-end character and the 0x1D0F residue are both exercised. An abort is forced by seven ones in mid-frame, followed by a clean frame to show the receiver recovers.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CHAR_W = 8;
  localparam int CRC_W  = 16;

  localparam logic [CRC_W-1:0] POLY_BYTE = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_BIT  = 16'h1021;
  localparam logic [CRC_W-1:0] INIT_BYTE = 16'h0000;
  localparam logic [CRC_W-1:0] INIT_BIT  = 16'hFFFF;
  localparam logic [CRC_W-1:0] RES_BYTE  = 16'h0000;
  localparam logic [CRC_W-1:0] RES_BIT   = 16'h1D0F;

  typedef enum logic [1:0] {ST_HUNT, ST_SYNC, ST_ACTIVE} rx_state_e;

  typedef struct packed {
    logic              blkend;
    logic              match;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  // Bits enter in line order (bit 0 of the character first), register shifts left.
  function automatic logic [CRC_W-1:0] crc_char(input logic [CRC_W-1:0] cur,
                                                input logic [CHAR_W-1:0] ch,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    c = cur;
    for (int i = 0; i < CHAR_W; i++) begin
      if (c[CRC_W-1] ^ ch[i]) c = {c[CRC_W-2:0], 1'b0} ^ poly;
      else                    c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_destuff.sv
module rxf_destuff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_vld,
  input  logic bit_in,
  output logic dat_vld,
  output logic dat_bit,
  output logic flag,
  output logic abort
);
  localparam int RUN_W = 3;
  localparam logic [RUN_W-1:0] STUFF_AT = 3'd5;
  localparam logic [RUN_W-1:0] FLAG_AT  = 3'd6;
  localparam logic [RUN_W-1:0] RUN_MAX  = 3'd7;

  logic [RUN_W-1:0] ones_q;

  always_comb begin
    dat_vld = 1'b0;
    flag    = 1'b0;
    abort   = 1'b0;
    dat_bit = bit_in;
    if (en && bit_vld) begin
      if (bit_in) begin
        if (ones_q >= FLAG_AT)       abort   = 1'b1;
        else if (ones_q != STUFF_AT) dat_vld = 1'b1;
      end else begin
        if (ones_q == FLAG_AT)       flag    = 1'b1;
        else if (ones_q != STUFF_AT) dat_vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ones_q <= '0;
    else if (clr || !en)       ones_q <= '0;
    else if (bit_vld) begin
      if (!bit_in)             ones_q <= '0;
      else if (ones_q != RUN_MAX) ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxf_crc.sv
module rxf_crc
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_mode,
  input  logic              restart,
  input  logic              upd,
  input  logic [CHAR_W-1:0] ch,
  output logic              match
);
  logic [CRC_W-1:0] crc_q, crc_nx, base, init_v, poly_v, res_v;

  assign init_v = bit_mode ? INIT_BIT : INIT_BYTE;
  assign poly_v = bit_mode ? POLY_BIT : POLY_BYTE;
  assign res_v  = bit_mode ? RES_BIT  : RES_BYTE;
  assign base   = restart ? init_v : crc_q;
  assign crc_nx = crc_char(base, ch, poly_v);
  assign match  = (crc_nx == res_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= INIT_BYTE;
    else if (clr)     crc_q <= init_v;
    else if (upd)     crc_q <= crc_nx;
    else if (restart) crc_q <= init_v;
  end
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en, rd_en;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL_CNT);
  assign rd_en = pop && !empty;
  assign wr_en = push && (!full || rd_en);
  assign rdata = mem[rp_q];

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (rd_en) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxf_receiver.sv
module rxf_receiver
  import rxf_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mode,
  input  logic [CHAR_W-1:0] sync_char,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_match,
  output logic              out_blkend,
  output logic              rx_active
);
  localparam int ENT_W = $bits(rx_entry_t);
  localparam int CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

  rx_state_e        st_q, st_d;
  logic [CHAR_W-2:0] sh_q, sh_d;
  logic [CHAR_W-1:0] sh_nx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       scnt_q, scnt_d;
  rx_entry_t        pend_q, pend_d, push_ent, head;
  logic             pvld_q, pvld_d;
  logic             push, pop, crc_upd, crc_rst, crc_match;
  logic             dst_vld, dst_bit, dst_flag, dst_abort;
  logic             ff_empty, ff_full;
  logic [ENT_W-1:0] ff_rdata;

  rxf_destuff u_destuff (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(mode),
    .bit_vld(rx_bit_vld), .bit_in(rx_bit),
    .dat_vld(dst_vld), .dat_bit(dst_bit), .flag(dst_flag), .abort(dst_abort)
  );

  assign sh_nx = {(mode ? dst_bit : rx_bit), sh_q};

  rxf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_mode(mode),
    .restart(crc_rst), .upd(crc_upd), .ch(sh_nx), .match(crc_match)
  );

  always_comb begin
    st_d = st_q; sh_d = sh_q; cnt_d = cnt_q; scnt_d = scnt_q;
    pend_d = pend_q; pvld_d = pvld_q;
    push = 1'b0; push_ent = '0; crc_upd = 1'b0; crc_rst = 1'b0;
    if (!mode) begin
      if (rx_bit_vld) begin
        sh_d = sh_nx[CHAR_W-1:1];
        unique case (st_q)
          ST_HUNT: begin
            if (sh_nx == sync_char) begin
              st_d = ST_SYNC; scnt_d = 2'd1; cnt_d = '0;
            end
          end
          ST_SYNC: begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (sh_nx == sync_char) scnt_d = 2'd2;
              else if (scnt_q == 2'd2) begin
                st_d = ST_ACTIVE; crc_rst = 1'b1; crc_upd = 1'b1;
                push = 1'b1; push_ent = '{blkend: 1'b0, match: crc_match, data: sh_nx};
              end else st_d = ST_HUNT;
            end
          end
          default: begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              crc_upd = 1'b1;
              push = 1'b1; push_ent = '{blkend: 1'b0, match: crc_match, data: sh_nx};
            end
          end
        endcase
      end
    end else begin
      if (dst_abort) begin
        st_d = ST_HUNT; pvld_d = 1'b0;
      end else if (dst_flag) begin
        if (st_q == ST_ACTIVE && pvld_q) begin
          push = 1'b1; push_ent = '{blkend: 1'b1, match: pend_q.match, data: pend_q.data};
        end
        pvld_d = 1'b0; st_d = ST_SYNC; cnt_d = '0; crc_rst = 1'b1;
      end else if (dst_vld && st_q != ST_HUNT) begin
        sh_d  = sh_nx[CHAR_W-1:1];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          crc_upd = 1'b1;
          if (pvld_q) begin push = 1'b1; push_ent = pend_q; end
          pend_d = '{blkend: 1'b0, match: crc_match, data: sh_nx};
          pvld_d = 1'b1; st_d = ST_ACTIVE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT; sh_q <= '0; cnt_q <= '0; scnt_q <= '0;
      pend_q <= '0; pvld_q <= 1'b0;
    end else if (clr) begin
      st_q <= ST_HUNT; sh_q <= '0; cnt_q <= '0; scnt_q <= '0;
      pend_q <= '0; pvld_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; cnt_q <= cnt_d; scnt_q <= scnt_d;
      pend_q <= pend_d; pvld_q <= pvld_d;
    end
  end

  assign pop = out_vld && out_rdy;

  rxf_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .wdata(push_ent),
    .pop(pop), .rdata(ff_rdata), .empty(ff_empty), .full(ff_full)
  );

  assign head       = rx_entry_t'(ff_rdata);
  assign out_vld    = !ff_empty;
  assign out_data   = head.data;
  assign out_match  = head.match;
  assign out_blkend = head.blkend;
  assign rx_active  = (st_q == ST_ACTIVE);
endmodule

// File: rtl/rxf_receiver_chk.sv
module rxf_receiver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       mode,
  input logic       out_vld,
  input logic       out_rdy,
  input logic [7:0] out_data,
  input logic       out_match,
  input logic       out_blkend,
  input logic       rx_active,
  input logic       abort,
  input logic       fifo_full,
  input logic       fifo_pop
);
  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_vld && !rx_active)); // R9

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy && !clr) |=> (out_vld && $stable(out_data) &&
      $stable(out_match) && $stable(out_blkend))); // R7

  AST_BYTE_ACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && !mode && !clr) |=> (rx_active || mode)); // R2

  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !fifo_pop && !clr) |=> fifo_full); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !rx_active); // R4
endmodule

bind rxf_receiver rxf_receiver_chk u_rxf_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode),
  .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data),
  .out_match(out_match), .out_blkend(out_blkend), .rx_active(rx_active),
  .abort(dst_abort), .fifo_full(ff_full), .fifo_pop(pop)
);

// File: tb/rxf_receiver_bench.sv
module rxf_receiver_bench;
  logic       clk = 1'b0, rst_n = 1'b0, clr = 1'b0, mode = 1'b0;
  logic       rx_bit_vld = 1'b0, rx_bit = 1'b1, out_rdy = 1'b0;
  logic [7:0] sync_char = 8'h96;
  logic       out_vld, out_match, out_blkend, rx_active;
  logic [7:0] out_data;

  int n_cmp = 0, n_bad = 0, tb_ones = 0;
  logic [9:0] exp_q[$];

  always #4 clk = ~clk;

  rxf_receiver u_rxf_receiver (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .sync_char(sync_char),
    .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .out_vld(out_vld), .out_rdy(out_rdy),
    .out_data(out_data), .out_match(out_match), .out_blkend(out_blkend),
    .rx_active(rx_active)
  );

  function automatic logic [15:0] f_crc(input logic [15:0] c, input logic [7:0] b,
                                        input logic [15:0] p);
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = c[15] ^ b[k];
      c  = c << 1;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit_vld = 1'b1; rx_bit = b;
    @(negedge clk); rx_bit_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) send_bit(v[k]);
  endtask

  task automatic send_stuffed(input logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      send_bit(v[k]);
      if (v[k]) begin
        tb_ones++;
        if (tb_ones == 5) begin send_bit(1'b0); tb_ones = 0; end
      end else tb_ones = 0;
    end
  endtask

  task automatic send_flag();
    send_byte(8'h7E); tb_ones = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; tb_ones = 0;
  endtask

  task automatic drain(input string mtag);
    while (exp_q.size() > 0) begin
      logic [9:0] e;
      e = exp_q.pop_front();
      repeat ($urandom_range(0, 2)) @(negedge clk);
      check("R7 valid", out_vld, 1);
      check("R7 data", out_data, e[7:0]);
      check(mtag, out_match, e[8]);
      check("R6 block end", out_blkend, e[9]);
      out_rdy = 1'b1;
      @(negedge clk); out_rdy = 1'b0;
    end
    check("R7 empty after drain", out_vld, 0);
  endtask

  // kind 0: random payload, kind 1: payload holding sync-valued characters
  task automatic byte_frame(input int n, input int kind, input logic bad);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'h0;
    send_byte(8'hFF); send_byte(8'hFF);
    send_byte(sync_char); send_byte(sync_char);
    check("R1 idle before data", rx_active, 0);
    for (int i = 0; i < n; i++) begin
      if (kind == 1) b = (i == 0) ? 8'h41 : ((i == n - 1) ? 8'h00 : sync_char);
      else b = 8'($urandom);
      if (i == 0 && b == sync_char) b = b ^ 8'h01;
      send_byte(b);
      if (i == 0) check("R1 active after first data", rx_active, 1);
      c = f_crc(c, b, 16'h8005);
      exp_q.push_back({1'b0, (c == 16'h0), b});
    end
    begin
      logic [15:0] f;
      f = bad ? (c ^ 16'h0100) : c;
      for (int k = 0; k < 8; k++) b[k] = f[15 - k];
      send_byte(b); c = f_crc(c, b, 16'h8005); exp_q.push_back({1'b0, (c == 16'h0), b});
      for (int k = 0; k < 8; k++) b[k] = f[7 - k];
      send_byte(b); c = f_crc(c, b, 16'h8005); exp_q.push_back({1'b0, (c == 16'h0), b});
    end
    check("R2 stays active", rx_active, 1);
  endtask

  // kind 0: random payload, kind 1: runs of ones forcing stuffed zeros
  task automatic bit_frame(input int n, input int kind, input logic bad);
    logic [15:0] c, f;
    logic [7:0]  b;
    c = 16'hFFFF;
    send_byte(8'hFF);
    send_flag(); send_flag();
    for (int i = 0; i < n; i++) begin
      b = (kind == 1) ? ((i % 2) ? 8'h7E : 8'hFF) : 8'($urandom);
      send_stuffed(b);
      if (i == 0) check("R5 active after first char", rx_active, 1);
      c = f_crc(c, b, 16'h1021);
      exp_q.push_back({1'b0, (c == 16'h1D0F), b});
    end
    f = ~c;
    if (bad) f = f ^ 16'h0001;
    for (int k = 0; k < 8; k++) b[k] = f[15 - k];
    send_stuffed(b); c = f_crc(c, b, 16'h1021); exp_q.push_back({1'b0, (c == 16'h1D0F), b});
    for (int k = 0; k < 8; k++) b[k] = f[7 - k];
    send_stuffed(b); c = f_crc(c, b, 16'h1021); exp_q.push_back({1'b1, (c == 16'h1D0F), b});
    send_flag();
    check("R6 inactive after closing flag", rx_active, 0);
  endtask

  initial begin
    #(8 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R10 reset out_vld", out_vld, 0);
    check("R10 reset active", rx_active, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // byte mode, random frames
    byte_frame(6, 0, 1'b0);
    drain("R3 match");
    do_clear();
    byte_frame(4, 1, 1'b0);          // R2: sync-valued data kept
    drain("R3 match");
    do_clear();
    byte_frame(5, 0, 1'b1);          // R3: corrupted check
    drain("R3 match bad");

    // R1: single sync then data must not activate
    do_clear();
    send_byte(8'hFF); send_byte(sync_char); send_byte(8'h00);
    send_byte(8'hFF); send_byte(8'hFF);
    check("R1 single sync inactive", rx_active, 0);
    check("R1 single sync nothing stored", out_vld, 0);
    byte_frame(3, 0, 1'b0);
    drain("R3 match");

    // R8: overflow
    do_clear();
    begin
      logic [15:0] c;
      logic [7:0]  b;
      c = 16'h0;
      send_byte(8'hFF); send_byte(sync_char); send_byte(sync_char);
      for (int i = 0; i < 70; i++) begin
        b = 8'($urandom);
        if (i == 0 && b == sync_char) b = b ^ 8'h01;
        send_byte(b);
        c = f_crc(c, b, 16'h8005);
        if (i < 64) exp_q.push_back({1'b0, (c == 16'h0), b});
      end
    end
    check("R8 full keeps head", out_vld, 1);
    drain("R8 match");

    // R9: clear flushes
    do_clear();
    send_byte(8'hFF); send_byte(sync_char); send_byte(sync_char);
    send_byte(8'h11); send_byte(8'h22);
    check("R9 stored before clear", out_vld, 1);
    do_clear();
    check("R9 flushed", out_vld, 0);
    check("R9 inactive", rx_active, 0);

    // bit mode
    @(negedge clk); mode = 1'b1;
    do_clear();
    for (int r = 0; r < 4; r++) begin
      bit_frame($urandom_range(1, 8), 0, 1'b0);
      drain("R5 match");
    end
    bit_frame(6, 1, 1'b0);           // R4: stuffing corner
    drain("R4 destuffed match");
    bit_frame(3, 0, 1'b1);           // R5: bad check
    drain("R5 match bad");

    // R4: abort drops the held character
    begin
      logic [15:0] c;
      logic [7:0]  b;
      c = 16'hFFFF;
      send_byte(8'hFF); send_flag();
      for (int i = 0; i < 3; i++) begin
        b = 8'($urandom);
        send_stuffed(b);
        c = f_crc(c, b, 16'h1021);
        if (i < 2) exp_q.push_back({1'b0, (c == 16'h1D0F), b});
      end
      for (int k = 0; k < 9; k++) send_bit(1'b1);
      tb_ones = 0;
      check("R4 abort inactive", rx_active, 0);
      drain("R4 match");
    end
    bit_frame(2, 0, 1'b0);           // recovery after abort
    drain("R4 recovery match");

    report();
  end
endmodule